// File: doc/BRIEF.md
# Multi-Width Serial Flash Device-Side Interface

This block is the slave side of the serial link of a flash memory. It watches the chip-select and serial clock pins and four data pins. Each data pin has its own input, output and output-enable signal. The block turns the serial stream into an opcode strobe, one 24-bit address word and a series of write-data bytes for the command layer behind it. For read-type opcodes it takes bytes from the command layer and shifts them back out on one, two or four lines.

The system clock runs much faster than the serial clock. All pins pass through a synchronizer and the serial clock edges are found by comparing successive samples. Because of this, mode 0 and mode 3 hosts are both served without configuration. The opcode byte always arrives on line 0. A small decode table in the package then fixes, for each opcode, whether an address follows, whether data goes in or out, and how many lines each phase uses. The write-protect level from pin 2 is reported to the command layer, except during a four-line transfer, where that pin carries data.

Top module: `sflash_frontend`

## Requirements
- R1: Opcode, address and write-data bits are taken on rising serial-clock edges, and read-data bits change only on falling edges. The first read bit appears on the first falling edge after the last opcode or address bit.
- R2: In single-line phases the opcode, address and write data enter on line 0, and read data leaves only on line 1. `dq_oe` is 4'b0010 for a one-line read, 4'b0011 for a two-line read, 4'b1111 for a four-line read, and 4'b0000 otherwise.
- R3: While chip select is high, `dq_oe` is 4'b0000 and no strobe is produced.
- R4: After reset, a high-to-low chip-select transition is required before any opcode is accepted. A select already low during reset produces no strobe.
- R5: Both serial-clock idle levels work: a select with the clock idling high (mode 3) and one with it idling low (mode 0) decode the same way.
- R6: In a two-line phase, each pair of bits is sent most significant pair first, and bit 1 of a pair is on line 1 and bit 0 on line 0.
- R7: In a four-line phase, each nibble is sent high nibble first, and bit k of the nibble is on line k.
- R8: `wr_protect` is 1 when pin 2 is low and the current selection has not decoded a four-line opcode. Once a four-line opcode is decoded, `wr_protect` stays 0 until deselect, whatever the level of pin 2.
- R9: If chip select rises part-way through a byte, the partial byte is dropped, no strobe is produced, and the next selection starts with an opcode.
- R10: Opcode table, as address lines / data direction / data lines:
  - 8'h03: 1 / out / 1
  - 8'hBB: 2 / out / 2
  - 8'hEB: 4 / out / 4
  - 8'h02: 1 / in / 1
  - 8'h32: 1 / in / 4
  - 8'h05: none / out / 1
  - 8'h01: none / in / 1
  - anything else: none / none

  `cmd_valid` pulses once per opcode. The 24-bit address, most significant byte first, appears with a single `addr_valid` pulse.
- R11: Each completed write-data byte appears on `wdata` with one `wdata_valid` pulse, in order.
- R12: `rd_take` pulses once each time a read byte is loaded from `rd_data`, which is one pulse per byte shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select, active low |
| sck_pin | input | 1 | Serial clock |
| dq_in | input | 4 | Input side of data lines 0..3 (line 2 doubles as write protect) |
| dq_out | output | 4 | Output side of data lines 0..3 |
| dq_oe | output | 4 | Output enable per data line |
| cmd_valid | output | 1 | Opcode byte received |
| cmd_op | output | 8 | Received opcode |
| addr_valid | output | 1 | Address word complete |
| addr | output | 24 | Received address |
| wdata_valid | output | 1 | Write byte complete |
| wdata | output | 8 | Received write byte |
| rd_take | output | 1 | Read byte consumed from rd_data |
| rd_data | input | 8 | Next read byte from the command layer |
| wr_protect | output | 1 | Write protect asserted by the pin |

## Verification
The bench sends opcode, address and data through every lane width. It uses one-line reads and writes, two-line reads, four-line reads, a four-line write after a one-line address, and an opcode-only status read.

Distinct address and data patterns make a wrong line order or a wrong pair or nibble order show as a miscompare. Mode 0 and mode 3 selects separate edge handling from clock idle level.

A select held low through reset, a selection dropped after five bits, and write-protect levels during single and quad opcodes separate arming, abort and pin-role behaviour from the plain data path.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

    typedef enum logic [2:0] {
        LN1 = 3'd1,
        LN2 = 3'd2,
        LN4 = 3'd4
    } lanes_t;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_IN   = 2'd1,
        DIR_OUT  = 2'd2
    } dir_t;

    typedef enum logic [2:0] {
        PH_OPC  = 3'd0,
        PH_ADR  = 3'd1,
        PH_WR   = 3'd2,
        PH_RD   = 3'd3,
        PH_SKIP = 3'd4
    } phase_t;

    typedef struct packed {
        logic   has_addr;
        lanes_t addr_ln;
        dir_t   dir;
        lanes_t data_ln;
    } opinfo_t;

    function automatic opinfo_t decode_op(input logic [7:0] op);
        opinfo_t r;
        case (op)
            8'h03:   r = '{1'b1, LN1, DIR_OUT,  LN1};
            8'hBB:   r = '{1'b1, LN2, DIR_OUT,  LN2};
            8'hEB:   r = '{1'b1, LN4, DIR_OUT,  LN4};
            8'h02:   r = '{1'b1, LN1, DIR_IN,   LN1};
            8'h32:   r = '{1'b1, LN1, DIR_IN,   LN4};
            8'h05:   r = '{1'b0, LN1, DIR_OUT,  LN1};
            8'h01:   r = '{1'b0, LN1, DIR_IN,   LN1};
            default: r = '{1'b0, LN1, DIR_NONE, LN1};
        endcase
        return r;
    endfunction

    function automatic logic uses_quad(input opinfo_t i);
        return (i.has_addr && i.addr_ln == LN4) ||
               (i.dir != DIR_NONE && i.data_ln == LN4);
    endfunction

    function automatic phase_t data_phase(input opinfo_t i);
        case (i.dir)
            DIR_OUT: return PH_RD;
            DIR_IN:  return PH_WR;
            default: return PH_SKIP;
        endcase
    endfunction

    function automatic logic [3:0] drive_mask(input lanes_t l);
        case (l)
            LN2:     return 4'b0011;
            LN4:     return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[i] <= '0;
            else     st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/sflash_rx.sv
module sflash_rx
    import sflash_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift,
    input  lanes_t            lanes,
    input  logic [3:0]        din,
    output logic              done,
    output logic [BYTE_W-1:0] byte_nxt
);
    localparam int CW = $clog2(BYTE_W) + 1;

    logic [BYTE_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cnt_nxt;

    always_comb begin
        case (lanes)
            LN2:     byte_nxt = {sh[BYTE_W-3:0], din[1:0]};
            LN4:     byte_nxt = {sh[BYTE_W-5:0], din[3:0]};
            default: byte_nxt = {sh[BYTE_W-2:0], din[0]};
        endcase
        cnt_nxt = cnt + CW'(lanes);
    end

    assign done = shift && (cnt_nxt == CW'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
            if (rst) sh <= '0;
        end else if (shift) begin
            sh  <= byte_nxt;
            cnt <= done ? '0 : cnt_nxt;
        end
    end
endmodule

// File: rtl/sflash_tx.sv
module sflash_tx
    import sflash_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       fall,
    input  lanes_t     lanes,
    input  logic [7:0] rd_data,
    output logic [3:0] dq_out,
    output logic [3:0] dq_oe,
    output logic       rd_take
);
    logic [7:0] osh;
    logic [3:0] orem;
    logic       loaded;

    assign rd_take = en && fall && (orem == 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            osh    <= '0;
            orem   <= '0;
            loaded <= 1'b0;
        end else if (!en) begin
            orem   <= '0;
            loaded <= 1'b0;
        end else if (fall) begin
            if (orem == 4'd0) begin
                osh    <= rd_data;
                orem   <= 4'd8 - 4'(lanes);
                loaded <= 1'b1;
            end else begin
                osh  <= osh << lanes;
                orem <= orem - 4'(lanes);
            end
        end
    end

    always_comb begin
        case (lanes)
            LN2:     dq_out = {2'b00, osh[7:6]};
            LN4:     dq_out = osh[7:4];
            default: dq_out = {2'b00, osh[7], 1'b0};
        endcase
        dq_oe = (en && loaded) ? drive_mask(lanes) : 4'b0000;
    end
endmodule

// File: rtl/sflash_frontend.sv
module sflash_frontend
    import sflash_pkg::*;
#(
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int ABW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_pin,
    input  logic              sck_pin,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic              cmd_valid,
    output logic [7:0]        cmd_op,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              wdata_valid,
    output logic [7:0]        wdata,
    output logic              rd_take,
    input  logic [7:0]        rd_data,
    output logic              wr_protect
);
    logic [5:0] syn;
    logic       cs_q, sck_q, cs_d, sck_d;
    logic [3:0] dq_q;

    sflash_sync #(.W(6), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n_pin, sck_pin, dq_in}),
        .q   (syn)
    );

    assign cs_q  = syn[5];
    assign sck_q = syn[4];
    assign dq_q  = syn[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_q;
            sck_d <= sck_q;
        end
    end

    logic sck_rise, sck_fall, cs_fall;
    assign sck_rise = sck_q & ~sck_d;
    assign sck_fall = ~sck_q & sck_d;
    assign cs_fall  = cs_d & ~cs_q;

    logic sel_ok, active;
    always_ff @(posedge clk) begin
        if (rst || cs_q) sel_ok <= 1'b0;
        else if (cs_fall) sel_ok <= 1'b1;
    end
    assign active = sel_ok & ~cs_q;

    phase_t            phase;
    opinfo_t           info;
    logic              quad_q;
    logic [ABW-1:0]    abyte;
    logic [ADDR_W-1:0] addr_sh, addr_nxt;
    lanes_t            rx_lanes;
    logic              rx_shift, rx_done;
    logic [7:0]        rx_byte;
    opinfo_t           dec;

    always_comb begin
        case (phase)
            PH_ADR:  rx_lanes = info.addr_ln;
            PH_WR:   rx_lanes = info.data_ln;
            default: rx_lanes = LN1;
        endcase
    end

    assign rx_shift = sck_rise && active &&
                      (phase == PH_OPC || phase == PH_ADR || phase == PH_WR);

    sflash_rx #(.BYTE_W(8)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .clear    (~active),
        .shift    (rx_shift),
        .lanes    (rx_lanes),
        .din      (dq_q),
        .done     (rx_done),
        .byte_nxt (rx_byte)
    );

    assign dec      = decode_op(rx_byte);
    assign addr_nxt = (ADDR_W > 8) ? {addr_sh[ADDR_W-9:0], rx_byte} : ADDR_W'(rx_byte);

    always_ff @(posedge clk) begin
        cmd_valid   <= 1'b0;
        addr_valid  <= 1'b0;
        wdata_valid <= 1'b0;
        if (rst) begin
            phase   <= PH_OPC;
            info    <= '{1'b0, LN1, DIR_NONE, LN1};
            quad_q  <= 1'b0;
            abyte   <= '0;
            addr_sh <= '0;
            addr    <= '0;
            cmd_op  <= '0;
            wdata   <= '0;
        end else if (!active) begin
            phase  <= PH_OPC;
            quad_q <= 1'b0;
            abyte  <= '0;
        end else if (rx_done) begin
            case (phase)
                PH_OPC: begin
                    cmd_op    <= rx_byte;
                    cmd_valid <= 1'b1;
                    info      <= dec;
                    quad_q    <= uses_quad(dec);
                    abyte     <= '0;
                    phase     <= dec.has_addr ? PH_ADR : data_phase(dec);
                end
                PH_ADR: begin
                    addr_sh <= addr_nxt;
                    if (abyte == ABW'(ADDR_BYTES - 1)) begin
                        addr       <= addr_nxt;
                        addr_valid <= 1'b1;
                        phase      <= data_phase(info);
                    end else begin
                        abyte <= abyte + 1'b1;
                    end
                end
                PH_WR: begin
                    wdata       <= rx_byte;
                    wdata_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    sflash_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .en      (active && phase == PH_RD),
        .fall    (sck_fall),
        .lanes   (info.data_ln),
        .rd_data (rd_data),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe),
        .rd_take (rd_take)
    );

    assign wr_protect = ~dq_q[2] & ~quad_q;
endmodule

// File: rtl/sflash_frontend_chk.sv
module sflash_frontend_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_q,
    input logic       sel_ok,
    input logic       quad_q,
    input logic [3:0] dq_oe,
    input logic       cmd_valid,
    input logic       addr_valid,
    input logic       wdata_valid,
    input logic       rd_take,
    input logic       wr_protect
);
    assert_oe_deselect_R3: assert property (@(posedge clk) disable iff (rst)
        cs_q |-> dq_oe == 4'b0000);

    assert_oe_code_R2: assert property (@(posedge clk) disable iff (rst)
        dq_oe == 4'b0000 || dq_oe == 4'b0010 || dq_oe == 4'b0011 || dq_oe == 4'b1111);

    assert_armed_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || addr_valid || wdata_valid) |-> $past(sel_ok));

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, addr_valid, wdata_valid}));

    assert_quad_no_protect_R8: assert property (@(posedge clk) disable iff (rst)
        quad_q |-> !wr_protect);

    assert_take_selected_R12: assert property (@(posedge clk) disable iff (rst)
        rd_take |-> (sel_ok && !cs_q));
endmodule

bind sflash_frontend sflash_frontend_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_q        (cs_q),
    .sel_ok      (sel_ok),
    .quad_q      (quad_q),
    .dq_oe       (dq_oe),
    .cmd_valid   (cmd_valid),
    .addr_valid  (addr_valid),
    .wdata_valid (wdata_valid),
    .rd_take     (rd_take),
    .wr_protect  (wr_protect)
);

// File: tb/tb_sflash_frontend.sv
module tb_sflash_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b0;
    logic        sck = 1'b0;
    logic [3:0]  dq_drv = 4'b0100;
    logic        wp_lvl = 1'b1;
    logic [3:0]  dq_out, dq_oe;
    logic        cmd_valid, addr_valid, wdata_valid, rd_take, wr_protect;
    logic [7:0]  cmd_op, wdata, rd_data;
    logic [23:0] addr;

    int checks = 0;
    int fails  = 0;
    int n_cmd = 0, n_addr = 0, n_wd = 0, rd_idx = 0;
    logic [7:0]  last_op = '0;
    logic [23:0] last_addr = '0;
    logic [7:0]  wd_log [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_frontend dut (
        .clk (clk), .rst (rst), .cs_n_pin (cs_n), .sck_pin (sck),
        .dq_in (dq_drv), .dq_out (dq_out), .dq_oe (dq_oe),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .addr_valid (addr_valid), .addr (addr),
        .wdata_valid (wdata_valid), .wdata (wdata),
        .rd_take (rd_take), .rd_data (rd_data), .wr_protect (wr_protect)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'h5A ^ 8'((i * 29) + 3);
    endfunction

    assign rd_data = pat(rd_idx);

    always @(posedge clk) begin
        if (cmd_valid)   begin n_cmd  <= n_cmd + 1;  last_op   <= cmd_op; end
        if (addr_valid)  begin n_addr <= n_addr + 1; last_addr <= addr;   end
        if (wdata_valid) begin wd_log[n_wd % 16] <= wdata; n_wd <= n_wd + 1; end
        if (rd_take)     rd_idx <= rd_idx + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_group(input logic [3:0] din, output logic [3:0] dout,
                               output logic [3:0] oe);
        sck = 1'b0;
        dq_drv = din;
        wait_clk(HALF);
        dout = dq_out;
        oe   = dq_oe;
        sck  = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic sel(input logic idle_hi);
        sck = idle_hi;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4);
        sck = 1'b0;
        dq_drv = {1'b0, wp_lvl, 2'b00};
        wait_clk(2 * HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int ln, input int nbits,
                             output logic [3:0] oe_or);
        logic [3:0] d, o, g;
        oe_or = '0;
        for (int k = 0; k < nbits / ln; k++) begin
            g = 4'((int'(b) >> (8 - ln * (k + 1))) & ((1 << ln) - 1));
            if (ln < 4) g[2] = wp_lvl;
            shift_group(g, d, o);
            oe_or |= o;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int ln, output logic [3:0] oe_or);
        send_bits(b, ln, 8, oe_or);
    endtask

    task automatic recv_byte(input int ln, output logic [7:0] r, output logic [3:0] oe_or);
        logic [3:0] d, o, g;
        r = '0;
        oe_or = '0;
        for (int k = 0; k < 8 / ln; k++) begin
            shift_group((ln < 4) ? {1'b0, wp_lvl, 2'b00} : 4'b0000, d, o);
            case (ln)
                1:       g = {3'b000, d[1]};
                2:       g = {2'b00, d[1:0]};
                default: g = d;
            endcase
            r = 8'((int'(r) << ln) | int'(g));
            oe_or |= o;
        end
    endtask

    task automatic send_addr(input logic [23:0] a, input int ln);
        logic [3:0] o;
        for (int i = 2; i >= 0; i--) send_byte(a[i*8 +: 8], ln, o);
    endtask

    task automatic do_read(input string req, input logic [7:0] op, input logic [23:0] a,
                           input logic has_a, input int aln, input int dln,
                           input logic mode3, input logic [3:0] exp_oe);
        logic [3:0] o;
        logic [7:0] r;
        int c0, a0, s0;
        c0 = n_cmd; a0 = n_addr;
        sel(mode3);
        send_byte(op, 1, o);
        chk(req, "opcode strobe", 32'(n_cmd - c0), 1);
        chk(req, "opcode value", 32'(last_op), 32'(op));
        if (has_a) begin
            send_addr(a, aln);
            chk(req, "addr strobe", 32'(n_addr - a0), 1);
            chk(req, "addr value", 32'(last_addr), 32'(a));
        end
        chk("R1", "no drive before read", 32'(dq_oe), 0);
        s0 = rd_idx;
        for (int i = 0; i < 2; i++) begin
            recv_byte(dln, r, o);
            chk(req, $sformatf("read byte %0d", i), 32'(r), 32'(pat(s0 + i)));
            chk("R2", "read oe", 32'(o), 32'(exp_oe));
        end
        chk("R12", "take count", 32'(rd_idx - s0), 2);
        desel();
        chk("R3", "oe after deselect", 32'(dq_oe), 0);
    endtask

    task automatic t_reset_unarmed();
        logic [3:0] o;
        wait_clk(8);
        rst = 1'b0;
        wait_clk(4);
        chk("R3", "reset oe", 32'(dq_oe), 0);
        send_byte(8'h05, 1, o);
        chk("R4", "no cmd when low at reset", 32'(n_cmd), 0);
        send_byte(8'h00, 1, o);
        chk("R4", "no drive when unarmed", 32'(o), 0);
        cs_n = 1'b1;
        sck = 1'b0;
        wait_clk(2 * HALF);
        chk("R3", "idle oe", 32'(dq_oe), 0);
    endtask

    task automatic t_program(input string req, input logic [7:0] op, input int dln,
                             input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1);
        logic [3:0] o, acc;
        int w0;
        w0 = n_wd;
        sel(1'b0);
        send_byte(op, 1, acc);
        send_addr(a, 1);
        chk("R10", "program addr", 32'(last_addr), 32'(a));
        send_byte(d0, dln, o); acc |= o;
        send_byte(d1, dln, o); acc |= o;
        chk(req, "wdata count", 32'(n_wd - w0), 2);
        chk(req, "wdata 0", 32'(wd_log[w0 % 16]), 32'(d0));
        chk(req, "wdata 1", 32'(wd_log[(w0 + 1) % 16]), 32'(d1));
        chk("R2", "no drive on write", 32'(acc), 0);
        desel();
    endtask

    task automatic t_abort();
        logic [3:0] o;
        int c0;
        c0 = n_cmd;
        sel(1'b0);
        send_bits(8'h02, 1, 5, o);
        desel();
        chk("R9", "partial opcode dropped", 32'(n_cmd - c0), 0);
        do_read("R9", 8'h05, 24'h0, 1'b0, 1, 1, 1'b0, 4'b0010);
    endtask

    task automatic t_wp();
        logic [3:0] o;
        int w0;
        w0 = n_wd;
        wp_lvl = 1'b0;
        sel(1'b0);
        send_byte(8'h01, 1, o);
        chk("R8", "protect in single", 32'(wr_protect), 1);
        send_byte(8'h7E, 1, o);
        chk("R11", "status write data", 32'(wd_log[w0 % 16]), 32'h7E);
        desel();
        sel(1'b1);
        send_byte(8'hEB, 1, o);
        chk("R8", "no protect in quad", 32'(wr_protect), 0);
        desel();
        wp_lvl = 1'b1;
        dq_drv = 4'b0100;
        wait_clk(2 * HALF);
        chk("R8", "pin high no protect", 32'(wr_protect), 0);
    endtask

    initial begin : main
        t_reset_unarmed();
        do_read("R1", 8'h03, 24'h123456, 1'b1, 1, 1, 1'b0, 4'b0010);
        do_read("R5", 8'h03, 24'hE1C3A5, 1'b1, 1, 1, 1'b1, 4'b0010);
        do_read("R6", 8'hBB, 24'h00A5C3, 1'b1, 2, 2, 1'b1, 4'b0011);
        wp_lvl = 1'b0;
        do_read("R7", 8'hEB, 24'h0F1E2D, 1'b1, 4, 4, 1'b0, 4'b1111);
        wp_lvl = 1'b1;
        do_read("R10", 8'h05, 24'h0, 1'b0, 1, 1, 1'b0, 4'b0010);
        t_program("R11", 8'h02, 1, 24'h00ABCD, 8'h3C, 8'hC3);
        t_program("R7", 8'h32, 4, 24'h0F0F0F, 8'h96, 8'h81);
        t_abort();
        t_wp();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule